// File: doc/BRIEF.md
# Windowed Watchdog Timer with Configuration Lock

This block is a watchdog counter clocked by a slow watchdog clock and controlled through a flat register interface. Each write takes effect at one clock edge, and reads are combinational. Once the block is enabled, the counter advances one step per cycle. If the counter is not cleared before the selected timeout, it raises a one-cycle reset request and sets a sticky timeout flag. Two optional checks add supervision. An early warning sets a flag at a fixed fraction of the timeout. An illegal-window check flags a clear that comes before a fixed fraction of the timeout has passed.

Configuration decides how the counter is cleared. The clear can come from a software command, or from a rising edge on an external event input. A debug halt input and two sleep inputs freeze the counter unless the matching run bit is set. A 16-bit key sequence locks and unlocks the enable and configuration registers. The interrupt output is the OR of the sticky flags that are enabled.

Top module: `wdt_window`

## Requirements
- R1: Period code n (config bits 11:8) gives a timeout of T = 2^(n+3)+1 cycles. A counting step taken while the count is at or above 2^(n+3) sets the timeout flag (flags bit 0) and returns the count to 0. The count is readable at address 7.
- R2: At each timeout, `rst_req` is high for exactly the following cycle, unless reset-disable (config bit 4) is 1. The timeout flag is set in both cases.
- R3: Warning code k (config bits 13:12, with 0 meaning off) sets the warning flag (flags bit 1) when the count steps to k·2^(n+1).
- R4: Window code m (config bits 18:16, with 0 meaning off) sets the window flag (flags bit 2) when a clear takes effect while the count is below m·2^n. A clear at or above that value leaves the flag unchanged.
- R5: When clear-source (config bit 0) is 0, writing 1 to bit 0 of address 2 zeroes the count. When it is 1, that write is ignored, and only a rising edge of `evt_in` zeroes the count. A held level clears nothing further.
- R6: Writing 0 to bits 15:0 of address 5 locks the block, and writing 0xABE8 unlocks it. Other values change nothing. Status bit 0 at address 6 reads 1 when locked, and the block is unlocked after reset. While locked, writes to address 0 (enable) and address 1 (config) are ignored. Clear commands and writes to flags and interrupt enables still work.
- R7: Flags are sticky and are cleared by writing 1 to their bit at address 3. A hardware set in the same cycle takes priority over the clear.
- R8: `irq` is high exactly when some flag bit is 1 and its enable bit at address 4 (same bit positions) is also 1.
- R9: The count holds its value while `dbg_halt` is 1 and debug-run (config bit 3) is 0. It also holds while `slp_a` is 1 and config bit 1 is 0, and while `slp_b` is 1 and config bit 2 is 0.
- R10: When enable (address 0, bit 0) is 0, the count is held at 0 and no flag or reset is raised. Reset leaves enable at 0, the count at 0 and all flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Combinational read data |
| evt_in | input | 1 | External clear event |
| dbg_halt | input | 1 | Debug halt state |
| slp_a | input | 1 | First sleep state |
| slp_b | input | 1 | Second sleep state |
| irq | output | 1 | Masked interrupt |
| rst_req | output | 1 | Watchdog reset request pulse |

## Verification
The bench goes after the cycle on which the timeout fires. A design off by one on the limit would report a timeout one cycle early or late, and would pulse the reset for the wrong length. It also clears a flag in the same cycle that hardware sets it, where a design that let software win would lose the timeout. It clears on either side of the window threshold, where a design using the wrong comparison would flag legal clears. It holds the external event high, where a level-sensitive clear would pin the count at zero. Writes made while locked must leave the configuration unchanged, or the lock would protect nothing. A random phase changes configuration, freeze inputs and lock keys while the count is running. It exposes thresholds that are wrong for large counts, and counters that miss the wrap after a shorter period has been chosen.

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int PSEL_W = 4,
  parameter int PBASE = 3,
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] OPEN_KEY = 16'hABE8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              evt_in,
  input  logic              dbg_halt,
  input  logic              slp_a,
  input  logic              slp_b,
  output logic              irq,
  output logic              rst_req
);
  localparam int CNT_W = (1 << PSEL_W) + PBASE;
  localparam logic [DATA_W-1:0] CFG_MASK = 32'h0007_3F1F;
  localparam logic [CNT_W-1:0] ONE = 1;
  localparam logic [ADDR_W-1:0] A_CTRL = 0, A_CFG = 1, A_CLR = 2, A_FLG = 3,
                                A_IEN = 4, A_KEY = 5, A_STAT = 6, A_CNT = 7;

  logic              en_q, lock_q, evt_q, rst_q;
  logic [DATA_W-1:0] cfg_q;
  logic [2:0]        flg_q, ien_q;
  logic [CNT_W-1:0]  cnt_q;

  wire              src_ext = cfg_q[0];
  wire              run_a   = cfg_q[1];
  wire              run_b   = cfg_q[2];
  wire              run_dbg = cfg_q[3];
  wire              rst_off = cfg_q[4];
  wire [PSEL_W-1:0] psel    = cfg_q[8 +: PSEL_W];
  wire [1:0]        wsel    = cfg_q[13:12];
  wire [2:0]        msel    = cfg_q[18:16];

  wire run = en_q & ~(dbg_halt & ~run_dbg) & ~(slp_a & ~run_a) & ~(slp_b & ~run_b);
  wire wr_here_clr = wr_en & (wr_addr == A_CLR);
  wire sw_clr  = wr_here_clr & wr_data[0] & ~src_ext;
  wire ext_clr = src_ext & evt_in & ~evt_q;
  wire clr_evt = en_q & (sw_clr | ext_clr);

  wire [CNT_W-1:0] lim     = ONE << (psel + PBASE);
  wire [CNT_W-1:0] warn_pt = ({{(CNT_W-2){1'b0}}, wsel} << (psel + 1)) - ONE;
  wire [CNT_W-1:0] win_pt  = {{(CNT_W-3){1'b0}}, msel} << psel;

  wire step     = run & ~clr_evt;
  wire tout_hit = step & (cnt_q >= lim);
  wire warn_hit = step & (wsel != 2'd0) & (cnt_q == warn_pt);
  wire win_hit  = clr_evt & (msel != 3'd0) & (cnt_q < win_pt);
  wire [2:0] set_v = {win_hit, warn_hit, tout_hit};
  wire [2:0] w1c   = (wr_en && wr_addr == A_FLG) ? wr_data[2:0] : 3'b000;

  assign irq     = |(flg_q & ien_q);
  assign rst_req = rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
      evt_q  <= 1'b0;
      rst_q  <= 1'b0;
      cfg_q  <= '0;
      flg_q  <= '0;
      ien_q  <= '0;
      cnt_q  <= '0;
    end else begin
      evt_q <= evt_in;
      rst_q <= tout_hit & ~rst_off;
      flg_q <= (flg_q & ~w1c) | set_v;
      if (wr_en && wr_addr == A_IEN) ien_q <= wr_data[2:0];
      if (wr_en && wr_addr == A_KEY) begin
        if (wr_data[KEY_W-1:0] == OPEN_KEY) lock_q <= 1'b0;
        else if (wr_data[KEY_W-1:0] == '0) lock_q <= 1'b1;
      end
      if (wr_en && !lock_q && wr_addr == A_CTRL) en_q <= wr_data[0];
      if (wr_en && !lock_q && wr_addr == A_CFG) cfg_q <= wr_data & CFG_MASK;
      if (!en_q || clr_evt) cnt_q <= '0;
      else if (run) cnt_q <= (cnt_q >= lim) ? '0 : cnt_q + ONE;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data[0] = en_q;
      A_CFG:  rd_data = cfg_q;
      A_FLG:  rd_data[2:0] = flg_q;
      A_IEN:  rd_data[2:0] = ien_q;
      A_STAT: rd_data[0] = lock_q;
      A_CNT:  rd_data[CNT_W-1:0] = cnt_q;
      default: rd_data = '0;
    endcase
  end

  AST_RST_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> flg_q[0]); // R2
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req); // R2
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n) clr_evt |=> cnt_q == '0); // R5
  AST_LOCK_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n) lock_q |=> $stable(cfg_q)); // R6
  AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && dbg_halt && !run_dbg && !clr_evt) |=> $stable(cnt_q)); // R9
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !en_q |=> cnt_q == '0); // R10
endmodule

// File: tb/wdt_window_test.sv
module wdt_window_test;
  logic clk = 0, rst_n = 0, wr_en = 0, evt_in = 0, dbg_halt = 0, slp_a = 0, slp_b = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic irq, rst_req;
  int checks = 0, errors = 0;
  bit done = 0;

  wdt_window uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_in(evt_in), .dbg_halt(dbg_halt), .slp_a(slp_a),
    .slp_b(slp_b), .irq(irq), .rst_req(rst_req));

  always #5 clk = ~clk;

  // reference model built from the requirements
  bit m_en, m_lock, m_evtq, m_rst;
  bit [31:0] m_cfg;
  bit [2:0] m_flg, m_ien;
  int unsigned m_cnt;

  function automatic int unsigned lim_of(bit [31:0] c);
    return 32'd1 << (c[11:8] + 3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_lock = 0; m_evtq = 0; m_rst = 0; m_cfg = 0; m_flg = 0; m_ien = 0; m_cnt = 0;
    end else begin
      bit run, clr, stp;
      bit [2:0] setv, clrv;
      int unsigned n;
      n = m_cfg[11:8];
      run = m_en && !(dbg_halt && !m_cfg[3]) && !(slp_a && !m_cfg[1]) && !(slp_b && !m_cfg[2]);
      clr = m_en && ((!m_cfg[0] && wr_en && wr_addr == 2 && wr_data[0]) || (m_cfg[0] && evt_in && !m_evtq));
      stp = run && !clr;
      setv[0] = stp && m_cnt >= lim_of(m_cfg);
      setv[1] = stp && m_cfg[13:12] != 0 && m_cnt + 1 == (m_cfg[13:12] << (n + 1));
      setv[2] = clr && m_cfg[18:16] != 0 && m_cnt < (m_cfg[18:16] << n);
      clrv = (wr_en && wr_addr == 3) ? wr_data[2:0] : 3'b0;
      m_rst = setv[0] && !m_cfg[4];
      m_flg = (m_flg & ~clrv) | setv;
      m_evtq = evt_in;
      if (!m_en || clr) m_cnt = 0;
      else if (run) m_cnt = (m_cnt >= lim_of(m_cfg)) ? 0 : m_cnt + 1;
      if (wr_en && wr_addr == 4) m_ien = wr_data[2:0];
      if (wr_en && !m_lock && wr_addr == 0) m_en = wr_data[0];
      if (wr_en && !m_lock && wr_addr == 1) m_cfg = wr_data & 32'h0007_3F1F;
      if (wr_en && wr_addr == 5) begin
        if (wr_data[15:0] == 16'hABE8) m_lock = 0;
        else if (wr_data[15:0] == 0) m_lock = 1;
      end
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_cnt(string req, int exp);
    logic [31:0] d;
    rd(7, d); chk(req, d, exp);
  endtask

  task automatic chk_flg(string req, int bitn, bit exp);
    logic [31:0] d;
    rd(3, d); chk(req, d[bitn], exp);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    cyc(3); rst_n = 1; cyc(1);
    // R10 reset state, R6 unlocked
    rd(6, d); chk("R6 reset unlocked", d[0], 0);
    chk_cnt("R10 reset count", 0);
    rd(3, d); chk("R10 reset flags", d[2:0], 0);
    chk("R10 reset irq", irq, 0);
    chk("R10 reset rst_req", rst_req, 0);

    wr(4, 7); wr(1, 32'h0000_2000); wr(0, 1); wr(2, 1);
    cyc(3); chk_cnt("R1 count runs", 3); chk_flg("R3 warn not yet", 1, 0);
    chk("R8 irq low", irq, 0);
    cyc(1); chk_flg("R3 warn at 50%", 1, 1); chk("R8 irq from warn", irq, 1);
    cyc(4); chk_cnt("R1 count before limit", 8); chk_flg("R1 no early timeout", 0, 0);
    chk("R2 no early reset", rst_req, 0);
    cyc(1); chk_flg("R1 timeout flag", 0, 1); chk_cnt("R1 wrap", 0); chk("R2 reset pulse", rst_req, 1);
    cyc(1); chk("R2 pulse one cycle", rst_req, 0);
    wr(3, 7); rd(3, d); chk("R7 w1c clears", d[2:0], 0); chk("R8 irq drops", irq, 0);

    wr(1, 32'h0000_0010); wr(2, 1); cyc(9);
    chk_flg("R2 flag with reset disabled", 0, 1); chk("R2 reset suppressed", rst_req, 0);
    wr(3, 7); wr(2, 1); cyc(8);
    wr(3, 1); chk_flg("R7 hardware set wins", 0, 1);

    wr(1, 32'h0004_0000); wr(2, 1); wr(3, 7); chk_flg("R4 setup clear", 2, 0);
    cyc(4); wr(2, 1); chk_flg("R4 legal clear", 2, 0);
    cyc(2); wr(2, 1); chk_flg("R4 early clear flagged", 2, 1);

    wr(1, 32'h0000_0001); cyc(2); chk_cnt("R5 pre", 3);
    wr(2, 1); chk_cnt("R5 sw clear ignored", 4);
    evt_in = 1; cyc(1); chk_cnt("R5 edge clears", 0);
    cyc(2); chk_cnt("R5 level no reclear", 2);
    evt_in = 0;

    wr(1, 0); wr(2, 1); dbg_halt = 1; cyc(3); chk_cnt("R9 debug freeze", 0);
    wr(1, 32'h0000_0008); cyc(3); chk_cnt("R9 debug run", 3);
    dbg_halt = 0; slp_a = 1; wr(1, 0); cyc(2); chk_cnt("R9 sleep a freeze", 3);
    slp_a = 0; slp_b = 1; cyc(2); chk_cnt("R9 sleep b freeze", 3);
    wr(1, 32'h0000_0004); cyc(2); chk_cnt("R9 sleep b run", 5);
    slp_b = 0;

    wr(5, 0); rd(6, d); chk("R6 locked", d[0], 1);
    wr(1, 32'h0000_0F00); rd(1, d); chk("R6 cfg held", d, 32'h4);
    wr(0, 0); wr(2, 1); cyc(2); chk_cnt("R6 enable held, clear allowed", 2);
    wr(5, 32'h1234); rd(6, d); chk("R6 other key ignored", d[0], 1);
    wr(5, 32'hABE8); rd(6, d); chk("R6 unlocked", d[0], 0);
    wr(1, 0); rd(1, d); chk("R6 cfg writable", d, 0);

    wr(0, 0); wr(3, 7); cyc(20);
    chk_cnt("R10 disabled count", 0); rd(3, d); chk("R10 no flags", d[2:0], 0);
    chk("R10 no reset", rst_req, 0);

    // random phase against the model (R1/R2/R3/R4/R5/R6/R7/R8/R9/R10)
    wr(0, 1);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) begin
        wr_en = 1; wr_addr = $urandom_range(0, 7);
        case (wr_addr)
          1: wr_data = $urandom & 32'h0007_331F;
          5: wr_data = ($urandom_range(0, 2) == 0) ? 32'h0 : (($urandom_range(0, 1) == 0) ? 32'hABE8 : $urandom);
          0: wr_data = ($urandom_range(0, 7) != 0);
          default: wr_data = $urandom;
        endcase
      end else wr_en = 0;
      if ($urandom_range(0, 3) == 0) evt_in = ~evt_in;
      if ($urandom_range(0, 15) == 0) dbg_halt = ~dbg_halt;
      if ($urandom_range(0, 15) == 0) slp_a = ~slp_a;
      if ($urandom_range(0, 15) == 0) slp_b = ~slp_b;
      @(negedge clk);
      wr_en = 0;
      rd(7, d); chk("R1 random count", d, m_cnt);
      rd(3, d); chk("R7 random flags", d[2:0], m_flg);
      rd(6, d); chk("R6 random lock", d[0], m_lock);
      chk("R8 random irq", irq, |(m_flg & m_ien));
      chk("R2 random reset", rst_req, m_rst);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule